// File: doc/BRIEF.md
# Carry-Save Nonrestoring Array Divider

This block divides a double-length dividend by a single-length divisor in one combinational array of N+1 rows. It uses the nonrestoring method. No row resolves its full partial remainder. Each row keeps the remainder as a pair of vectors, a sum vector and a carry vector, and folds the shifted divisor, true or inverted, into that pair with one 3-to-2 carry-save stage. A carry-lookahead term then settles only the sign position. The sign gives the row's quotient bit, and that same bit tells the next row whether to add or subtract the divisor. The delay of one row therefore does not depend on a carry rippling across the full operand width.

The block serves two uses. In fraction use, both operands are positive and normalized, so their top bits are set, and the quotient bits weigh 2^0 down to 2^-N. In integer use, a 2N-bit dividend is divided by an N-bit divisor. The upper half of the dividend must then be smaller than the divisor, so the quotient fits in N bits. A flag marks operand pairs that break the integer rule. The result can be registered at the output, or left combinational, under the control of a parameter. No remainder is produced.

Top module: `csa_nr_divider`

## Requirements
- R1: When the divisor is nonzero and the upper half of the dividend is less than twice the divisor, quotient_o equals floor(dividend/divisor) as an (N+1)-bit value. quotient_o[N] is the bit resolved by the first row and carries weight 2^N. quotient_o[0] is the bit resolved by the last row.
- R2: When the divisor is nonzero and the upper half of the dividend (bits 2N-1..N) is below the divisor, ovf_o is 0 and quotient_o[N] is 0.
- R3: A zero divisor drives ovf_o to 1, and quotient_o is then unspecified.
- R4: When the upper half of the dividend is at least the divisor, ovf_o is 1. If in addition divisor bit N-1 is set, the quotient is still exact per R1 and quotient_o[N] is 1.
- R5: With normalized operands (dividend bit 2N-1 and divisor bit N-1 both set), the quotient is exact per R1 and at least one of quotient_o[N] and quotient_o[N-1] is 1.
- R6: With OUT_REG=1, the outputs take the result of the inputs present at a rising edge of clk_i and hold that result until the next rising edge, even if the inputs change in between. With OUT_REG=0, the outputs follow the inputs combinationally.
- R7: With OUT_REG=1, quotient_o and ovf_o are 0 while rst_ni is low.
- R8: For N >= 10, the sign-position lookahead is built in two levels, with groups of 4 bits feeding one group-level term, and the results match R1. For N < 10, the lookahead is a single sum of products.
- R9: A zero dividend with a nonzero divisor gives a zero quotient. A divisor of 1 with a zero upper half gives a quotient equal to the dividend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dividend_i | input | 2N | Double-length dividend; bits 2N-1..N form the upper half |
| divisor_i | input | N | Divisor |
| quotient_o | output | N+1 | Quotient, from bit N (first row) down to bit 0 (last row) |
| ovf_o | output | 1 | Divisor is zero or does not exceed the upper half of the dividend |

## Verification
The bench builds three copies of the block, at N = 4, N = 8 and N = 16, all with the output register on. N = 4 and N = 8 exercise the single-level lookahead. N = 16 reaches the two-level grouped lookahead, including a top group that is exactly full. Each width receives the same directed corners: a zero divisor, a unit divisor, an upper half equal to the divisor minus one, an upper half equal to the divisor, and the extreme normalized ratios. Each width also receives random integer and random normalized operands, all scored against plain integer division.

// File: rtl/csd_pkg.sv
`timescale 1ns/1ps
package csd_pkg;

  // lookahead goes two-level at this width (R8)
  localparam int unsigned LA_SPLIT = 10;
  localparam int unsigned LA_GROUP = 4;
  localparam int unsigned LA_MAX   = 32;

  // carry out of a w-bit sum: sum of generate terms, each masked by higher propagates
  function automatic logic la_sop(input logic [LA_MAX-1:0] g,
                                  input logic [LA_MAX-1:0] p,
                                  input int w,
                                  input logic cin);
    logic acc;
    logic term;
    logic pall;
    acc  = 1'b0;
    pall = cin;
    for (int j = 0; j < LA_MAX; j++) begin
      if (j < w) begin
        term = g[j];
        for (int k = j + 1; k < LA_MAX; k++) begin
          if (k < w) term = term & p[k];
        end
        acc  = acc | term;
        pall = pall & p[j];
      end
    end
    return acc | pall;
  endfunction

endpackage

// File: rtl/csd_lookahead.sv
`timescale 1ns/1ps
module csd_lookahead
  import csd_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] g_i,
  input  logic [W-1:0] p_i,
  input  logic         cin_i,
  output logic         c_o
);

  if (W < LA_SPLIT) begin : g_flat
    assign c_o = la_sop(LA_MAX'(g_i), LA_MAX'(p_i), W, cin_i);
  end else begin : g_two_level
    // R8: group terms first, then one term across groups
    localparam int unsigned NG = (W + LA_GROUP - 1) / LA_GROUP;
    localparam int unsigned PW = NG * LA_GROUP;

    logic [PW-1:0] g_pad;
    logic [PW-1:0] p_pad;
    logic [NG-1:0] grp_g;
    logic [NG-1:0] grp_p;

    // padding propagates and never generates
    always_comb begin
      g_pad = '0;
      p_pad = '1;
      g_pad[W-1:0] = g_i;
      p_pad[W-1:0] = p_i;
    end

    for (genvar gi = 0; gi < NG; gi++) begin : g_grp
      assign grp_g[gi] = la_sop(LA_MAX'(g_pad[gi*LA_GROUP +: LA_GROUP]),
                                LA_MAX'(p_pad[gi*LA_GROUP +: LA_GROUP]),
                                LA_GROUP, 1'b0);
      assign grp_p[gi] = &p_pad[gi*LA_GROUP +: LA_GROUP];
    end

    assign c_o = la_sop(LA_MAX'(grp_g), LA_MAX'(grp_p), NG, cin_i);
  end

endmodule

// File: rtl/csd_array.sv
`timescale 1ns/1ps
module csd_array #(
  parameter int unsigned N = 8
) (
  input  logic [2*N-1:0] dividend_i,
  input  logic [N-1:0]   divisor_i,
  output logic [N:0]     quot_o
);

  localparam int unsigned W = N + 1;

  logic [W-1:0] s_vec [0:N];
  logic [W-1:0] c_vec [0:N];
  logic [N:0]   qbit;

  assign s_vec[0] = {1'b0, dividend_i[2*N-1:N]};
  assign c_vec[0] = '0;

  for (genvar i = 0; i <= N; i++) begin : g_row
    logic         q_prev;
    logic [W-1:0] dy;
    logic [W-1:0] sp;
    logic [W-1:0] cp;
    logic [N-1:0] kk;
    logic [N-1:0] gen;
    logic [N-1:0] prp;
    logic         cl;

    // row 0 always subtracts
    if (i == 0) begin : g_first
      assign q_prev = 1'b1;
    end else begin : g_next
      assign q_prev = qbit[i-1];
    end

    // subtract: invert divisor, inject +1 in the vacated carry slot
    assign dy = {1'b0, divisor_i} ^ {W{q_prev}};
    assign sp = s_vec[i] ^ c_vec[i] ^ dy;
    assign kk = (s_vec[i][N-1:0] & c_vec[i][N-1:0])
              | (s_vec[i][N-1:0] & dy[N-1:0])
              | (c_vec[i][N-1:0] & dy[N-1:0]);
    assign cp = {kk, q_prev};

    assign gen = sp[N-1:0] & cp[N-1:0];
    assign prp = sp[N-1:0] | cp[N-1:0];

    csd_lookahead #(.W(N)) i_la (
      .g_i  (gen),
      .p_i  (prp),
      .cin_i(1'b0),
      .c_o  (cl)
    );

    // quotient bit = remainder non-negative
    assign qbit[i] = ~(sp[N] ^ cp[N] ^ cl);

    if (i < N) begin : g_shift
      assign s_vec[i+1] = {sp[N-1:0], dividend_i[N-1-i]};
      assign c_vec[i+1] = {cp[N-1:0], 1'b0};
    end
  end

  // R1: first row gives the top quotient bit
  for (genvar i = 0; i <= N; i++) begin : g_qmap
    assign quot_o[N-i] = qbit[i];
  end

endmodule

// File: rtl/csa_nr_divider.sv
`timescale 1ns/1ps
module csa_nr_divider #(
  parameter int unsigned N       = 8,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [2*N-1:0] dividend_i,
  input  logic [N-1:0]   divisor_i,
  output logic [N:0]     quotient_o,
  output logic           ovf_o
);

  logic [N:0] quot_d;
  logic       ovf_d;

  csd_array #(.N(N)) i_array (
    .dividend_i(dividend_i),
    .divisor_i (divisor_i),
    .quot_o    (quot_d)
  );

  // R3, R4
  assign ovf_d = (divisor_i == '0) || (dividend_i[2*N-1:N] >= divisor_i);

  if (OUT_REG) begin : g_reg
    // R6, R7
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        quotient_o <= '0;
        ovf_o      <= 1'b0;
      end else begin
        quotient_o <= quot_d;
        ovf_o      <= ovf_d;
      end
    end
  end else begin : g_comb
    assign quotient_o = quot_d;
    assign ovf_o      = ovf_d;
  end

endmodule

// File: rtl/csa_nr_divider_chk.sv
`timescale 1ns/1ps
module csa_nr_divider_chk #(
  parameter int unsigned N       = 8,
  parameter bit          OUT_REG = 1'b1
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [2*N-1:0] dividend_i,
  input logic [N-1:0]   divisor_i,
  input logic [N:0]     quotient_o,
  input logic           ovf_o
);

  logic [N-1:0] hi;
  assign hi = dividend_i[2*N-1:N];

  if (OUT_REG) begin : g_reg
    p_zero_div_ovf_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (divisor_i == '0) |=> ovf_o)
      else $error("p_zero_div_ovf_r3");

    p_int_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (divisor_i != '0 && hi < divisor_i) |=> (!ovf_o && !quotient_o[N]))
      else $error("p_int_range_r2");

    p_hi_ge_div_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (divisor_i[N-1] && hi >= divisor_i) |=> (ovf_o && quotient_o[N]))
      else $error("p_hi_ge_div_r4");

    p_norm_lead_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (divisor_i[N-1] && dividend_i[2*N-1]) |=> (quotient_o[N] || quotient_o[N-1]))
      else $error("p_norm_lead_r5");

    p_zero_dvd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dividend_i == '0 && divisor_i != '0) |=> (quotient_o == '0))
      else $error("p_zero_dvd_r9");
  end else begin : g_comb
    p_int_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (divisor_i != '0 && hi < divisor_i) |-> (!ovf_o && !quotient_o[N]))
      else $error("p_int_range_r2");

    p_hi_ge_div_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (divisor_i[N-1] && hi >= divisor_i) |-> (ovf_o && quotient_o[N]))
      else $error("p_hi_ge_div_r4");

    p_norm_lead_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (divisor_i[N-1] && dividend_i[2*N-1]) |-> (quotient_o[N] || quotient_o[N-1]))
      else $error("p_norm_lead_r5");

    p_zero_dvd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dividend_i == '0 && divisor_i != '0) |-> (quotient_o == '0))
      else $error("p_zero_dvd_r9");
  end

endmodule

bind csa_nr_divider csa_nr_divider_chk #(.N(N), .OUT_REG(OUT_REG)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .dividend_i(dividend_i),
  .divisor_i (divisor_i),
  .quotient_o(quotient_o),
  .ovf_o     (ovf_o)
);

// File: tb/test_csa_nr_divider.sv
`timescale 1ns/1ps
module test_csa_nr_divider_lane #(
  parameter int unsigned N = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);

  localparam logic [N-1:0] ONES = '1;
  localparam logic [N-1:0] MSB  = {1'b1, {(N-1){1'b0}}};

  int n_cmp = 0;
  int n_bad = 0;

  logic [2*N-1:0] a = '0;
  logic [N-1:0]   d = '0;
  logic [N:0]     q;
  logic           ovf;

  csa_nr_divider #(.N(N), .OUT_REG(1'b1)) i_csa_nr_divider (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .dividend_i(a),
    .divisor_i (d),
    .quotient_o(q),
    .ovf_o     (ovf)
  );

  typedef struct packed {
    logic [N:0] q;
    logic       ovf;
    logic       chk_q;
  } exp_t;

  exp_t  exp_fifo [$];
  string tag_fifo [$];
  exp_t  last_e = '0;

  // driver: apply at negedge, push expectation
  task automatic drive(input logic [2*N-1:0] av, input logic [N-1:0] dv,
                       input string tag, input bit hold_chk);
    longint unsigned ai;
    longint unsigned di;
    longint unsigned hi;
    exp_t e;
    @(negedge clk);
    a = av;
    d = dv;
    ai = 64'(av);
    di = 64'(dv);
    hi = ai >> N;
    e.ovf   = (di == 0) || (hi >= di);
    e.chk_q = (di != 0) && (hi < 2 * di);
    e.q     = e.chk_q ? (N+1)'(ai / di) : '0;
    if (hold_chk) begin
      // R6: no edge yet, outputs must still carry the previous result
      #1;
      n_cmp++;
      if (ovf !== last_e.ovf || (last_e.chk_q && q !== last_e.q)) begin
        n_bad++;
        $display("FAIL R6 N=%0d hold: quotient=%h ovf=%b expected quotient=%h ovf=%b",
                 N, q, ovf, last_e.q, last_e.ovf);
      end
    end
    exp_fifo.push_back(e);
    tag_fifo.push_back(tag);
    last_e = e;
  endtask

  // monitor: result registered at the edge after the drive
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_fifo.size() > 0) begin
        exp_t  e;
        string t;
        e = exp_fifo.pop_front();
        t = tag_fifo.pop_front();
        n_cmp++;
        if (ovf !== e.ovf || (e.chk_q && q !== e.q)) begin
          n_bad++;
          $display("FAIL %s N=%0d: quotient=%h ovf=%b expected quotient=%h ovf=%b",
                   t, N, q, ovf, e.q, e.ovf);
        end
      end
    end
  end

  initial begin
    done = 1'b0;
    repeat (2) @(negedge clk);
    // R7: reset state
    n_cmp++;
    if (rst_n !== 1'b0 || q !== '0 || ovf !== 1'b0) begin
      n_bad++;
      $display("FAIL R7 N=%0d reset: quotient=%h ovf=%b expected quotient=0 ovf=0", N, q, ovf);
    end
    @(posedge rst_n);

    drive({ {N{1'b0}}, {N{1'b0}} }, N'(1), "R9 zero dividend", 1'b0);
    drive({ {N{1'b0}}, ONES }, N'(1), "R9 unit divisor", 1'b0);
    drive({ MSB, {N{1'b0}} }, '0, "R3 zero divisor", 1'b0);
    drive({ ONES - N'(1), ONES }, ONES, "R2 largest fitting quotient", 1'b0);
    drive({ MSB | N'(1), ONES }, MSB | N'(1), "R4 upper half equals divisor", 1'b0);
    drive({ ONES, ONES }, MSB, "R5 largest normalized ratio", 1'b0);
    drive({ MSB, {N{1'b0}} }, ONES, "R5 smallest normalized ratio", 1'b1);
    drive({ ONES, {N{1'b0}} }, N'(1), "R4 quotient overflow", 1'b0);
    drive({ {N{1'b0}}, ONES }, N'(3), "R1 small divisor", 1'b0);

    // R1 / R2 (R8 at N>=10): random integer operands
    for (int k = 0; k < 150; k++) begin
      logic [N-1:0] dv;
      logic [N-1:0] hv;
      logic [N-1:0] lv;
      dv = N'($urandom());
      if (dv == '0) dv = N'(1);
      hv = N'(64'($urandom()) % 64'(dv));
      lv = N'($urandom());
      drive({hv, lv}, dv, (N >= 10) ? "R8 two-level integer" : "R1 integer", k[0]);
    end

    // R5 (R8 at N>=10): random normalized operands
    for (int k = 0; k < 150; k++) begin
      logic [N-1:0]   dv;
      logic [2*N-1:0] av;
      dv = N'($urandom()) | MSB;
      av = (2*N)'({$urandom(), $urandom()});
      av[2*N-1] = 1'b1;
      drive(av, dv, (N >= 10) ? "R8 two-level normalized" : "R5 normalized", 1'b0);
    end

    repeat (3) @(negedge clk);
    done = 1'b1;
  end

endmodule

module test_csa_nr_divider;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic done4;
  logic done8;
  logic done16;
  int   wd_bad = 0;

  // 250 MHz
  always #2 clk = ~clk;

  initial begin
    #1 rst_n = 1'b0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
  end

  test_csa_nr_divider_lane #(.N(4))  i_lane4  (.clk(clk), .rst_n(rst_n), .done(done4));
  test_csa_nr_divider_lane #(.N(8))  i_lane8  (.clk(clk), .rst_n(rst_n), .done(done8));
  test_csa_nr_divider_lane #(.N(16)) i_lane16 (.clk(clk), .rst_n(rst_n), .done(done16));

  initial begin
    int cyc;
    int total;
    int bad;
    cyc = 0;
    while (!(done4 === 1'b1 && done8 === 1'b1 && done16 === 1'b1) && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!(done4 === 1'b1 && done8 === 1'b1 && done16 === 1'b1)) begin
      wd_bad = 1;
      $display("FAIL watchdog: run did not complete, cycles=%0d expected < 20000", cyc);
    end
    total = i_lane4.n_cmp + i_lane8.n_cmp + i_lane16.n_cmp + wd_bad;
    bad   = i_lane4.n_bad + i_lane8.n_bad + i_lane16.n_bad + wd_bad;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
    $finish;
  end

endmodule